// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block is a hardware state machine that brings an analog storage-interface PHY out of power-down. When a power-on request arrives, it first drives both the power-down-bar and DLL-enable controls low, so that the PHY's calibration logic starts from a clean state. After a settle wait it releases power-down-bar. After a further trim wait it samples the calibration-done input. It then presents a frequency-range code to the PHY, raises DLL-enable, and polls DLL-ready once per microsecond until the lock limit runs out. The sequence ends in one of three held results: done, calibration error or DLL error.

The card-clock rate is measured elsewhere and arrives in kHz, together with a valid flag. The block sorts that rate into one of four ranges and raises a warning when the rate is too far from the nominal value of its range. A power-off request aborts any step at once and returns every output to its safe low state. All waits count a microsecond tick made from the system clock by a divider whose ratio is a parameter.

States: OFF (idle, outputs safe), SETTLE (both controls low, settle wait), TRIM (power-down-bar high, trim wait ending with the calibration sample), FREQ (one cycle presenting the range code), LOCK (DLL enabled, polling ready), READY (done), CAL_FAIL, LOCK_FAIL. Transitions: OFF/READY/CAL_FAIL/LOCK_FAIL to SETTLE on a power-on request; SETTLE to TRIM after SETTLE_US ticks; TRIM to FREQ or CAL_FAIL on the last trim tick; FREQ to LOCK after one cycle; LOCK to READY on a tick with ready high; LOCK to LOCK_FAIL on tick LOCK_US with ready low; any state to OFF on a power-off request.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, pdb_out, dll_en_out, done, err_cal, err_dll and rate_warn are 0 and freq_sel_out is 0.
- R2: A power-on request accepted at a clock edge holds pdb_out and dll_en_out low for exactly SETTLE_US*TICK_DIV cycles. pdb_out then goes high. Every wait is a whole number of ticks, each tick being TICK_DIV clock cycles.
- R3: The trim wait lasts TRIM_US ticks after pdb_out rises, and cal_done_in is sampled on its last tick. If the sample is low, err_cal is set and pdb_out and dll_en_out are both driven low.
- R4: The range code on freq_sel_out is 1 for rates below 75000 kHz, 2 for 75000 up to 124999 kHz, 3 for 125000 up to 174999 kHz, and 0 for 175000 kHz and above. The nominal rates of these ranges are 50000, 100000, 150000 and 200000 kHz.
- R5: When rate_valid is low at the request, the code is 0 and rate_warn stays 0.
- R6: freq_sel_out is 0 during the trim wait. It shows the range code for exactly one cycle with pdb_out high before dll_en_out rises, and it is unchanged on the cycle dll_en_out rises.
- R7: While dll_en_out is high, dll_ready_in is sampled once per tick. A high sample sets done, with pdb_out and dll_en_out kept high.
- R8: If dll_ready_in is still low at tick LOCK_US, err_dll is set and pdb_out and dll_en_out go low. This is LOCK_US*TICK_DIV cycles after dll_en_out rose.
- R9: rate_warn is captured at the request. It is 1 when the rate is above 50000 kHz and differs from its range's nominal rate by more than 15000 kHz, or when the rate is above 200000 kHz.
- R10: A power-on request made while a sequence is running is ignored and does not change its timing.
- R11: A power-off request returns all outputs to 0 on the next cycle from any state. It takes priority over a power-on request in the same cycle.
- R12: At most one of done, err_cal and err_dll is high. Each stays high until the next power-on or power-off request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Start a power-up sequence |
| pwr_off_req | input | 1 | Abort and power down |
| rate_valid | input | 1 | rate_khz holds a measured rate |
| rate_khz | input | RATE_W | Card-clock rate in kHz |
| cal_done_in | input | 1 | Calibration-done status from the PHY |
| dll_ready_in | input | 1 | DLL-ready status from the PHY |
| pdb_out | output | 1 | Power-down-bar control (1 = powered) |
| dll_en_out | output | 1 | DLL enable control |
| freq_sel_out | output | 2 | DLL frequency range code |
| done | output | 1 | Sequence completed |
| err_cal | output | 1 | Calibration not done at the end of the trim wait |
| err_dll | output | 1 | DLL did not lock within the limit |
| rate_warn | output | 1 | Rate off nominal or above the top range |

## Verification
The assertions take for granted that cal_done_in and dll_ready_in always carry known values. They also assume rate_khz and rate_valid are steady at the cycle a request is accepted, since code and warning are captured there. Request inputs are taken to be synchronous, so that done can only follow a sampled ready. The stimulus changes every input only at falling edges and pulses each request for one cycle. It sets the rate before issuing a request and leaves it alone until the sequence ends.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_TRIM,
        ST_FREQ,
        ST_LOCK,
        ST_READY,
        ST_CAL_FAIL,
        ST_LOCK_FAIL
    } seq_state_e;

    typedef logic [1:0] fcode_t;

    localparam fcode_t FC_TOP = 2'd0;
    localparam fcode_t FC_LOW = 2'd1;
    localparam fcode_t FC_MID = 2'd2;
    localparam fcode_t FC_UPR = 2'd3;

    // range edges and nominal rates, in kHz
    localparam int unsigned EDGE_LOW_MID = 75000;
    localparam int unsigned EDGE_MID_UPR = 125000;
    localparam int unsigned EDGE_UPR_TOP = 175000;
    localparam int unsigned NOM_LOW      = 50000;
    localparam int unsigned NOM_MID      = 100000;
    localparam int unsigned NOM_UPR      = 150000;
    localparam int unsigned NOM_TOP      = 200000;
    localparam int unsigned WARN_FLOOR   = 50000;
    localparam int unsigned WARN_SPAN    = 15000;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/rate_sorter.sv
module rate_sorter
    import phy_bringup_pkg::*;
#(
    parameter int RATE_W = 20
) (
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_khz,
    output fcode_t            code,
    output logic              warn
);
    logic [31:0] r;
    logic [31:0] nom;
    logic [31:0] dev;

    always_comb begin
        r = 32'(rate_khz);
        if (r < EDGE_LOW_MID) begin
            code = FC_LOW;
            nom  = NOM_LOW;
        end else if (r < EDGE_MID_UPR) begin
            code = FC_MID;
            nom  = NOM_MID;
        end else if (r < EDGE_UPR_TOP) begin
            code = FC_UPR;
            nom  = NOM_UPR;
        end else begin
            code = FC_TOP;
            nom  = NOM_TOP;
        end
        dev  = (r > nom) ? (r - nom) : (nom - r);
        warn = ((r > WARN_FLOOR) && (dev > WARN_SPAN)) || (r > NOM_TOP);
        if (!rate_valid) begin
            code = FC_TOP;
            warn = 1'b0;
        end
    end

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
    import phy_bringup_pkg::*;
#(
    parameter int SETTLE_US = 3,
    parameter int TRIM_US   = 5,
    parameter int LOCK_US   = 10000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   on_req,
    input  logic   off_req,
    input  logic   tick,
    input  logic   cal_done,
    input  logic   dll_ready,
    input  fcode_t code_in,
    input  logic   warn_in,
    output logic   tick_clr,
    output logic   pdb,
    output logic   dll_en,
    output fcode_t freq_sel,
    output logic   done,
    output logic   err_cal,
    output logic   err_dll,
    output logic   warn
);
    localparam int MAX_A   = (SETTLE_US > TRIM_US) ? SETTLE_US : TRIM_US;
    localparam int MAX_US  = (MAX_A > LOCK_US) ? MAX_A : LOCK_US;
    localparam int WCW     = $clog2(MAX_US + 1) + 1;
    localparam logic [WCW-1:0] SETTLE_LAST = WCW'(SETTLE_US - 1);
    localparam logic [WCW-1:0] TRIM_LAST   = WCW'(TRIM_US - 1);
    localparam logic [WCW-1:0] LOCK_LAST   = WCW'(LOCK_US - 1);

    seq_state_e     state_q, state_d;
    logic [WCW-1:0] wcnt_q, wcnt_d;
    fcode_t         fcode_q, fcode_d;
    logic           warn_q, warn_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            wcnt_q  <= '0;
            fcode_q <= FC_TOP;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            fcode_q <= fcode_d;
            warn_q  <= warn_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        fcode_d = fcode_q;
        warn_d  = warn_q;
        if (off_req) begin
            state_d = ST_OFF;
            wcnt_d  = '0;
            fcode_d = FC_TOP;
            warn_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_READY, ST_CAL_FAIL, ST_LOCK_FAIL: begin
                    if (on_req) begin
                        state_d = ST_SETTLE;
                        wcnt_d  = '0;
                        fcode_d = code_in;
                        warn_d  = warn_in;
                    end
                end
                ST_SETTLE: begin
                    if (tick) begin
                        if (wcnt_q == SETTLE_LAST) begin
                            state_d = ST_TRIM;
                            wcnt_d  = '0;
                        end else begin
                            wcnt_d = wcnt_q + WCW'(1);
                        end
                    end
                end
                ST_TRIM: begin
                    if (tick) begin
                        if (wcnt_q == TRIM_LAST) begin
                            state_d = cal_done ? ST_FREQ : ST_CAL_FAIL;
                            wcnt_d  = '0;
                        end else begin
                            wcnt_d = wcnt_q + WCW'(1);
                        end
                    end
                end
                ST_FREQ: begin
                    state_d = ST_LOCK;
                    wcnt_d  = '0;
                end
                ST_LOCK: begin
                    if (tick) begin
                        if (dll_ready) begin
                            state_d = ST_READY;
                            wcnt_d  = '0;
                        end else if (wcnt_q == LOCK_LAST) begin
                            state_d = ST_LOCK_FAIL;
                            wcnt_d  = '0;
                        end else begin
                            wcnt_d = wcnt_q + WCW'(1);
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    wcnt_d  = '0;
                end
            endcase
        end
    end

    assign tick_clr = (state_d != state_q);

    // outputs
    always_comb begin
        pdb      = 1'b0;
        dll_en   = 1'b0;
        freq_sel = FC_TOP;
        done     = 1'b0;
        err_cal  = 1'b0;
        err_dll  = 1'b0;
        warn     = warn_q;
        unique case (state_q)
            ST_TRIM: begin
                pdb = 1'b1;
            end
            ST_FREQ: begin
                pdb      = 1'b1;
                freq_sel = fcode_q;
            end
            ST_LOCK: begin
                pdb      = 1'b1;
                dll_en   = 1'b1;
                freq_sel = fcode_q;
            end
            ST_READY: begin
                pdb      = 1'b1;
                dll_en   = 1'b1;
                freq_sel = fcode_q;
                done     = 1'b1;
            end
            ST_CAL_FAIL:  err_cal = 1'b1;
            ST_LOCK_FAIL: err_dll = 1'b1;
            default: begin
                pdb = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_bringup_pkg::*;
#(
    parameter int TICK_DIV  = 125,
    parameter int SETTLE_US = 3,
    parameter int TRIM_US   = 5,
    parameter int LOCK_US   = 10000,
    parameter int RATE_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_req,
    input  logic              pwr_off_req,
    input  logic              rate_valid,
    input  logic [RATE_W-1:0] rate_khz,
    input  logic              cal_done_in,
    input  logic              dll_ready_in,
    output logic              pdb_out,
    output logic              dll_en_out,
    output logic [1:0]        freq_sel_out,
    output logic              done,
    output logic              err_cal,
    output logic              err_dll,
    output logic              rate_warn
);
    logic   tick;
    logic   tick_clr;
    fcode_t sorted_code;
    logic   sorted_warn;

    us_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    rate_sorter #(.RATE_W(RATE_W)) sort_i (
        .rate_valid (rate_valid),
        .rate_khz   (rate_khz),
        .code       (sorted_code),
        .warn       (sorted_warn)
    );

    bringup_fsm #(
        .SETTLE_US (SETTLE_US),
        .TRIM_US   (TRIM_US),
        .LOCK_US   (LOCK_US)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_req    (pwr_on_req),
        .off_req   (pwr_off_req),
        .tick      (tick),
        .cal_done  (cal_done_in),
        .dll_ready (dll_ready_in),
        .code_in   (sorted_code),
        .warn_in   (sorted_warn),
        .tick_clr  (tick_clr),
        .pdb       (pdb_out),
        .dll_en    (dll_en_out),
        .freq_sel  (freq_sel_out),
        .done      (done),
        .err_cal   (err_cal),
        .err_dll   (err_dll),
        .warn      (rate_warn)
    );

endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_on_req,
    input logic       pwr_off_req,
    input logic       dll_ready_in,
    input logic       pdb_out,
    input logic       dll_en_out,
    input logic [1:0] freq_sel_out,
    input logic       done,
    input logic       err_cal,
    input logic       err_dll
);
    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_cal, err_dll}));

    // R7
    dll_needs_pdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_out |-> pdb_out);

    // R6
    freq_before_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_out) |-> ($stable(freq_sel_out) && $past(pdb_out)));

    // R7
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(dll_ready_in) && $past(dll_en_out)));

    // R3
    cal_fail_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cal |-> (!pdb_out && !dll_en_out));

    // R8
    dll_fail_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_dll |-> (!pdb_out && !dll_en_out && freq_sel_out == 2'd0));

    // R11
    off_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req |=> (!pdb_out && !dll_en_out && !done && !err_cal && !err_dll));

    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pwr_on_req && !pwr_off_req) |=> done);

    // R12
    errs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_cal || err_dll) && !pwr_on_req && !pwr_off_req)
            |=> ($stable(err_cal) && $stable(err_dll)));

endmodule

bind phy_bringup_seq phy_bringup_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_on_req   (pwr_on_req),
    .pwr_off_req  (pwr_off_req),
    .dll_ready_in (dll_ready_in),
    .pdb_out      (pdb_out),
    .dll_en_out   (dll_en_out),
    .freq_sel_out (freq_sel_out),
    .done         (done),
    .err_cal      (err_cal),
    .err_dll      (err_dll)
);

// File: tb/phy_bringup_seq_tb_top.sv
module phy_bringup_seq_tb_top;
    localparam int DIV    = 4;
    localparam int SET_US = 3;
    localparam int TRM_US = 5;
    localparam int LCK_US = 20;
    localparam int RW     = 20;

    typedef struct packed {
        logic [RW-1:0] rate;
        logic [1:0]    code;
        logic          warn;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{20'd0,      2'd1, 1'b0},
        '{20'd30000,  2'd1, 1'b0},
        '{20'd50000,  2'd1, 1'b0},
        '{20'd65000,  2'd1, 1'b0},
        '{20'd66000,  2'd1, 1'b1},
        '{20'd74999,  2'd1, 1'b1},
        '{20'd75000,  2'd2, 1'b1},
        '{20'd100000, 2'd2, 1'b0},
        '{20'd124999, 2'd2, 1'b1},
        '{20'd125000, 2'd3, 1'b1},
        '{20'd150000, 2'd3, 1'b0},
        '{20'd174999, 2'd3, 1'b1},
        '{20'd175000, 2'd0, 1'b1},
        '{20'd200000, 2'd0, 1'b0},
        '{20'd200001, 2'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          on_req = 1'b0;
    logic          off_req = 1'b0;
    logic          rvalid = 1'b0;
    logic [RW-1:0] rate = '0;
    logic          cal = 1'b0;
    logic          rdy = 1'b0;
    logic          pdb, dllen, done, ecal, edll, warn;
    logic [1:0]    fsel;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    phy_bringup_seq #(
        .TICK_DIV (DIV), .SETTLE_US (SET_US), .TRIM_US (TRM_US),
        .LOCK_US (LCK_US), .RATE_W (RW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .pwr_on_req (on_req), .pwr_off_req (off_req),
        .rate_valid (rvalid), .rate_khz (rate), .cal_done_in (cal),
        .dll_ready_in (rdy), .pdb_out (pdb), .dll_en_out (dllen),
        .freq_sel_out (fsel), .done (done), .err_cal (ecal), .err_dll (edll),
        .rate_warn (warn)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_on();
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk); off_req = 1'b1;
        @(negedge clk); off_req = 1'b0;
    endtask

    task automatic count_while_low_pdb(output int n);
        n = 0;
        while (!pdb && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic count_trim(output int n, output int first_f, output int last_f);
        n = 0; first_f = fsel; last_f = fsel;
        while (pdb && !dllen && n < 5000) begin
            last_f = fsel; n++; @(negedge clk);
        end
    endtask

    task automatic count_lock(output int n);
        n = 0;
        while (dllen && !done && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_end();
        int c = 0;
        while (!(done || ecal || edll) && c < 5000) begin c++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, f0, f1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {pdb, dllen, done, ecal, edll, warn}, 0);
        chk("R1 freq", fsel, 0);

        // stimulus table: R4 and R9
        for (int i = 0; i < NV; i++) begin
            rvalid = 1'b1; rate = VECS[i].rate; cal = 1'b1; rdy = 1'b1;
            pulse_on();
            chk($sformatf("R9 warn %0d kHz", VECS[i].rate), warn, VECS[i].warn);
            wait_end();
            chk("R7 done", done, 1);
            chk($sformatf("R4 code %0d kHz", VECS[i].rate), fsel, VECS[i].code);
            pulse_off();
        end

        // timing run: R2, R3, R6, R7
        rvalid = 1'b1; rate = 20'd100000; cal = 1'b1; rdy = 1'b1;
        pulse_on();
        count_while_low_pdb(n);
        chk("R2 settle cycles", n, SET_US * DIV);
        count_trim(n, f0, f1);
        chk("R3 trim plus freq cycles", n, TRM_US * DIV + 1);
        chk("R6 freq zero in trim", f0, 0);
        chk("R6 freq shown before dll", f1, 2);
        count_lock(n);
        chk("R7 first tick lock cycles", n, DIV);
        chk("R7 done outputs", {done, pdb, dllen}, 7);
        repeat (30) @(negedge clk);
        chk("R12 done held", {done, ecal, edll}, 4);
        pulse_off();
        chk("R11 off clears done", {pdb, dllen, done, fsel}, 0);

        // R5 no rate
        rvalid = 1'b0; rate = 20'd150000;
        pulse_on();
        chk("R5 warn", warn, 0);
        wait_end();
        chk("R5 code", fsel, 0);
        pulse_off();

        // R3 calibration failure
        rvalid = 1'b1; rate = 20'd50000; cal = 1'b0;
        pulse_on();
        wait_end();
        chk("R3 err_cal", {done, ecal, edll}, 2);
        chk("R3 safe outputs", {pdb, dllen}, 0);
        repeat (20) @(negedge clk);
        chk("R12 err_cal held", {done, ecal, edll}, 2);

        // R8 lock timeout, started from an error state
        cal = 1'b1; rdy = 1'b0;
        pulse_on();
        chk("R12 flags cleared by request", {done, ecal, edll}, 0);
        count_while_low_pdb(n);
        count_trim(n, f0, f1);
        count_lock(n);
        chk("R8 lock window cycles", n, LCK_US * DIV);
        chk("R8 err_dll", {done, ecal, edll}, 1);
        chk("R8 safe outputs", {pdb, dllen, fsel}, 0);

        // R7 late lock
        pulse_on();
        count_while_low_pdb(n);
        count_trim(n, f0, f1);
        repeat (30) @(negedge clk);
        chk("R7 still polling", {dllen, done, edll}, 4);
        rdy = 1'b1;
        wait_end();
        chk("R7 late lock done", {done, edll}, 2);
        pulse_off();

        // R10 request during settle ignored
        rdy = 1'b1;
        pulse_on();
        n = 0;
        while (!pdb && n < 5000) begin
            if (n == 5) on_req = 1'b1;
            if (n == 6) on_req = 1'b0;
            n++; @(negedge clk);
        end
        chk("R10 settle unchanged", n, SET_US * DIV);
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
        chk("R10 trim not restarted", pdb, 1);
        wait_end();
        chk("R10 sequence completes", done, 1);
        pulse_off();

        // R11 abort during lock
        rdy = 1'b0;
        pulse_on();
        count_while_low_pdb(n);
        count_trim(n, f0, f1);
        repeat (5) @(negedge clk);
        pulse_off();
        chk("R11 abort outputs", {pdb, dllen, fsel, done, ecal, edll, warn}, 0);

        // R11 off wins over on
        @(negedge clk); on_req = 1'b1; off_req = 1'b1;
        @(negedge clk); on_req = 1'b0; off_req = 1'b0;
        repeat (SET_US * DIV + 8) @(negedge clk);
        chk("R11 off priority", {pdb, dllen, done, ecal, edll}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule